// File: doc/BRIEF.md
# Page Private/Shared Classifier

This block decides, page by page, whether memory belongs to a single core or is shared among several, so that a last-level cache can place a block next to its only user or spread it across the chip. It answers TLB-miss requests with a fill that carries a classification. The first core to touch a page becomes its owner and the page is private. A miss from a different core has two outcomes. If the thread moved, the old owner's cached copies are invalidated and the page is handed to the new core. If the page is really shared, it is poisoned while the old owner's TLB entry is shot down and its blocks are invalidated, and it comes back as shared for good.

Instruction fetches skip classification and get an instruction fill at once. Page walking, scheduling and the invalidation work itself live outside the block. They appear only as a request port, a fill port and a shoot-down command with an acknowledge. Misses that hit a poisoned page are parked in a small in-order queue and answered after the acknowledge arrives. Misses to any other page are held off through `req_ready` while the shoot-down is outstanding.

Top module: `pc_classifier`

## Requirements
- R1: After reset, the first non-instruction miss to a page records the requester as owner and answers one cycle after acceptance with `fill_class` = 2'b01 (private), echoing page and core.
- R2: A miss from the recorded owner of a private page returns private one cycle later and raises no shoot-down.
- R3: A mismatching miss with `req_migrate` = 1 raises `sd_valid` with `sd_kind` = 0 toward the old owner. After `sd_ack`, the requester gets a private fill and becomes the owner, so a later miss from it is private with no shoot-down.
- R4: A mismatching miss with `req_migrate` = 0 raises `sd_valid` with `sd_kind` = 1, `sd_core` = old owner and `sd_page` = page. That miss, and any further non-instruction miss to the same page, is accepted but not answered until `sd_ack`.
- R5: Starting two cycles after `sd_ack`, the parked requests are answered one per cycle in arrival order with `fill_class` = 2'b10 (shared).
- R6: A shared page answers shared to every core, with or without `req_migrate`, and never raises a shoot-down again.
- R7: A miss with `req_ifetch` = 1 returns `fill_class` = 2'b11 one cycle after acceptance, changes no table state, and is accepted even while a shoot-down is outstanding.
- R8: While a shoot-down is outstanding, `req_ready` is 0 for a non-instruction miss to another page, for any non-instruction miss during a migration, and for a same-page miss once the 4-entry queue is full. It is also 0 while the queue drains.
- R9: After reset `fill_valid` and `sd_valid` are 0, `req_ready` is 1 and every page is unclassified.
- R10: `sd_valid`, `sd_page`, `sd_core` and `sd_kind` hold steady until `sd_ack` is seen, and `sd_valid` drops the cycle after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | TLB-miss request present |
| req_ready | output | 1 | Request accepted this cycle when high with req_valid |
| req_page | input | PAGE_W | Page number (table index) |
| req_core | input | CORE_W | Requesting core |
| req_migrate | input | 1 | Hint that the requesting thread moved from another core |
| req_ifetch | input | 1 | Request comes from an instruction cache |
| fill_valid | output | 1 | Fill present for one cycle |
| fill_page | output | PAGE_W | Page of the fill |
| fill_core | output | CORE_W | Core that receives the fill |
| fill_class | output | 2 | 01 private, 10 shared, 11 instruction |
| sd_valid | output | 1 | Shoot-down/invalidate command pending |
| sd_page | output | PAGE_W | Page to invalidate |
| sd_core | output | CORE_W | Tile of the previous owner |
| sd_kind | output | 1 | 1 TLB shoot-down plus invalidate (sharing), 0 invalidate only (migration) |
| sd_ack | input | 1 | Single-cycle completion of the command |

## Verification
Every cycle, the assertions check the command handshake's stability, the instruction-fill latency, the stall rules while a command is outstanding, the queue bound and the absence of a shared fill for a poisoned page. The directed scenarios alone show the classification outcomes. These cover first-touch ownership across all sixteen pages, owner hits, the migration hand-over of ownership, arrival order and class of the parked fills, and permanence of the shared state.

// File: rtl/pc_pkg.sv
package pc_pkg;
  typedef enum logic [1:0] {
    CLS_NONE   = 2'b00,
    CLS_PRIV   = 2'b01,
    CLS_SHARED = 2'b10,
    CLS_INSTR  = 2'b11
  } cls_e;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'b00,
    ST_WAIT  = 2'b01,
    ST_DRAIN = 2'b10
  } st_e;
endpackage

// File: rtl/pc_table.sv
module pc_table #(
  parameter int N_ENTRIES = 16,
  parameter int PAGE_W    = 4,
  parameter int CORE_W    = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [PAGE_W-1:0] rd_page,
  output logic              rd_valid,
  output logic              rd_priv,
  output logic              rd_poison,
  output logic [CORE_W-1:0] rd_owner,
  input  logic              wr_en,
  input  logic [PAGE_W-1:0] wr_page,
  input  logic              wr_priv,
  input  logic              wr_poison,
  input  logic [CORE_W-1:0] wr_owner
);
  logic [N_ENTRIES-1:0] vld_q;
  logic [N_ENTRIES-1:0] priv_q;
  logic [N_ENTRIES-1:0] pois_q;
  logic [CORE_W-1:0]    own_mem [N_ENTRIES];

  always_ff @(posedge clk) begin
    if (rst) begin
      vld_q <= '0;
    end else if (wr_en) begin
      vld_q[wr_page] <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      priv_q <= '0;
      pois_q <= '0;
    end else if (wr_en) begin
      priv_q[wr_page] <= wr_priv;
      pois_q[wr_page] <= wr_poison;
    end
  end

  always_ff @(posedge clk) begin
    if (wr_en) own_mem[wr_page] <= wr_owner;
  end

  assign rd_valid  = vld_q[rd_page];
  assign rd_priv   = priv_q[rd_page];
  assign rd_poison = pois_q[rd_page];
  assign rd_owner  = own_mem[rd_page];
endmodule

// File: rtl/pc_fifo.sv
module pc_fifo #(
  parameter int DEPTH = 4,
  parameter int W     = 8,
  parameter int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             push,
  input  logic [W-1:0]     din,
  input  logic             pop,
  output logic [W-1:0]     dout,
  output logic [CNT_W-1:0] count,
  output logic             full,
  output logic             empty
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [W-1:0]     mem [DEPTH];
  logic [PTR_W-1:0] wr_ptr, rd_ptr;
  logic [CNT_W-1:0] cnt_q;

  function automatic logic [PTR_W-1:0] nxt(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (push && !full) mem[wr_ptr] <= din;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      cnt_q  <= '0;
    end else begin
      if (push && !full) wr_ptr <= nxt(wr_ptr);
      if (pop && !empty) rd_ptr <= nxt(rd_ptr);
      case ({push && !full, pop && !empty})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
    end
  end

  assign dout  = mem[rd_ptr];
  assign count = cnt_q;
  assign full  = (cnt_q == CNT_W'(DEPTH));
  assign empty = (cnt_q == '0);
endmodule

// File: rtl/pc_classifier.sv
module pc_classifier #(
  parameter int N_ENTRIES = 16,
  parameter int CORE_W    = 4,
  parameter int Q_DEPTH   = 4,
  parameter int PAGE_W    = $clog2(N_ENTRIES)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [PAGE_W-1:0] req_page,
  input  logic [CORE_W-1:0] req_core,
  input  logic              req_migrate,
  input  logic              req_ifetch,
  output logic              fill_valid,
  output logic [PAGE_W-1:0] fill_page,
  output logic [CORE_W-1:0] fill_core,
  output logic [1:0]        fill_class,
  output logic              sd_valid,
  output logic [PAGE_W-1:0] sd_page,
  output logic [CORE_W-1:0] sd_core,
  output logic              sd_kind,
  input  logic              sd_ack
);
  import pc_pkg::*;

  localparam int QW    = PAGE_W + CORE_W;
  localparam int CNT_W = $clog2(Q_DEPTH + 1);

  st_e state_q;

  logic              t_valid, t_priv, t_poison;
  logic [CORE_W-1:0] t_owner;
  logic              wr_en, wr_priv, wr_poison;
  logic [PAGE_W-1:0] wr_page;
  logic [CORE_W-1:0] wr_owner;

  logic              q_push, q_pop, q_full, q_empty;
  logic [QW-1:0]     q_dout;
  logic [CNT_W-1:0]  q_count;

  logic acc, acc_data, is_new, is_own, is_shared, is_mig, is_shr;

  pc_table #(
    .N_ENTRIES(N_ENTRIES), .PAGE_W(PAGE_W), .CORE_W(CORE_W)
  ) u_table (
    .clk(clk), .rst(rst),
    .rd_page(req_page),
    .rd_valid(t_valid), .rd_priv(t_priv), .rd_poison(t_poison), .rd_owner(t_owner),
    .wr_en(wr_en), .wr_page(wr_page), .wr_priv(wr_priv),
    .wr_poison(wr_poison), .wr_owner(wr_owner)
  );

  pc_fifo #(.DEPTH(Q_DEPTH), .W(QW)) u_pending (
    .clk(clk), .rst(rst),
    .push(q_push), .din({req_page, req_core}),
    .pop(q_pop), .dout(q_dout),
    .count(q_count), .full(q_full), .empty(q_empty)
  );

  // Accept rules per state
  always_comb begin
    case (state_q)
      ST_IDLE: req_ready = 1'b1;
      ST_WAIT: req_ready = req_ifetch ||
                           (sd_kind && t_poison && (req_page == sd_page) && !q_full);
      default: req_ready = 1'b0;
    endcase
  end

  assign acc       = req_valid && req_ready;
  assign acc_data  = acc && !req_ifetch;
  assign is_new    = !t_valid;
  assign is_shared = t_valid && !t_priv;
  assign is_own    = t_valid && t_priv && (t_owner == req_core);
  assign is_mig    = t_valid && t_priv && (t_owner != req_core) && req_migrate;
  assign is_shr    = t_valid && t_priv && (t_owner != req_core) && !req_migrate;

  assign q_push = acc_data && ((state_q == ST_IDLE) ? (is_mig || is_shr)
                                                    : (state_q == ST_WAIT));
  assign q_pop  = (state_q == ST_DRAIN) && !q_empty;

  // Single table write port
  always_comb begin
    wr_en     = 1'b0;
    wr_page   = req_page;
    wr_priv   = 1'b1;
    wr_poison = 1'b0;
    wr_owner  = req_core;
    if (state_q == ST_IDLE && acc_data) begin
      if (is_new || is_mig) begin
        wr_en = 1'b1;
      end else if (is_shr) begin
        wr_en     = 1'b1;
        wr_poison = 1'b1;
        wr_owner  = t_owner;
      end
    end else if (state_q == ST_WAIT && sd_ack && sd_kind) begin
      wr_en    = 1'b1;
      wr_page  = sd_page;
      wr_priv  = 1'b0;
      wr_owner = sd_core;
    end
  end

  // Fill register
  always_ff @(posedge clk) begin
    if (rst) begin
      fill_valid <= 1'b0;
      fill_page  <= '0;
      fill_core  <= '0;
      fill_class <= CLS_NONE;
    end else begin
      fill_valid <= 1'b0;
      if (q_pop) begin
        fill_valid <= 1'b1;
        {fill_page, fill_core} <= q_dout;
        fill_class <= sd_kind ? CLS_SHARED : CLS_PRIV;
      end else if (acc && req_ifetch) begin
        fill_valid <= 1'b1;
        fill_page  <= req_page;
        fill_core  <= req_core;
        fill_class <= CLS_INSTR;
      end else if (acc_data && state_q == ST_IDLE && !is_mig && !is_shr) begin
        fill_valid <= 1'b1;
        fill_page  <= req_page;
        fill_core  <= req_core;
        fill_class <= is_shared ? CLS_SHARED : CLS_PRIV;
      end
    end
  end

  // Shoot-down handshake and sequencing
  always_ff @(posedge clk) begin
    if (rst) begin
      state_q  <= ST_IDLE;
      sd_valid <= 1'b0;
      sd_page  <= '0;
      sd_core  <= '0;
      sd_kind  <= 1'b0;
    end else begin
      case (state_q)
        ST_IDLE: begin
          if (acc_data && (is_mig || is_shr)) begin
            state_q  <= ST_WAIT;
            sd_valid <= 1'b1;
            sd_page  <= req_page;
            sd_core  <= t_owner;
            sd_kind  <= is_shr;
          end
        end
        ST_WAIT: begin
          if (sd_ack) begin
            state_q  <= ST_DRAIN;
            sd_valid <= 1'b0;
          end
        end
        default: begin
          if (q_empty || (q_pop && q_count == CNT_W'(1))) state_q <= ST_IDLE;
        end
      endcase
    end
  end
endmodule

// File: rtl/pc_classifier_chk.sv
module pc_classifier_chk #(
  parameter int CORE_W  = 4,
  parameter int Q_DEPTH = 4,
  parameter int PAGE_W  = 4,
  parameter int CNT_W   = $clog2(Q_DEPTH + 1)
) (
  input logic              clk,
  input logic              rst,
  input logic              req_valid,
  input logic              req_ready,
  input logic [PAGE_W-1:0] req_page,
  input logic              req_ifetch,
  input logic              fill_valid,
  input logic [PAGE_W-1:0] fill_page,
  input logic [1:0]        fill_class,
  input logic              sd_valid,
  input logic [PAGE_W-1:0] sd_page,
  input logic [CORE_W-1:0] sd_core,
  input logic              sd_kind,
  input logic              sd_ack,
  input logic [CNT_W-1:0]  q_count
);
  a_r10_sd_hold: assert property (@(posedge clk) disable iff (rst)
    sd_valid && !sd_ack |=> sd_valid && $stable(sd_page) && $stable(sd_core) && $stable(sd_kind));

  a_r10_sd_release: assert property (@(posedge clk) disable iff (rst)
    sd_valid && sd_ack |=> !sd_valid);

  a_r7_ifetch_fill: assert property (@(posedge clk) disable iff (rst)
    req_valid && req_ready && req_ifetch |=> fill_valid && fill_class == 2'b11);

  a_r8_mig_blocks_data: assert property (@(posedge clk) disable iff (rst)
    sd_valid && !sd_kind && req_ready |-> req_ifetch);

  a_r8_other_page_stall: assert property (@(posedge clk) disable iff (rst)
    sd_valid && sd_kind && req_ready && !req_ifetch |-> req_page == sd_page);

  a_r8_no_overflow: assert property (@(posedge clk) disable iff (rst)
    q_count <= CNT_W'(Q_DEPTH));

  a_r4_no_shared_while_poisoned: assert property (@(posedge clk) disable iff (rst)
    sd_valid && sd_kind |-> !(fill_valid && fill_class == 2'b10 && fill_page == sd_page));

  a_r1_fill_class_legal: assert property (@(posedge clk) disable iff (rst)
    fill_valid |-> fill_class != 2'b00);
endmodule

bind pc_classifier pc_classifier_chk #(
  .CORE_W(CORE_W), .Q_DEPTH(Q_DEPTH), .PAGE_W(PAGE_W)
) u_chk (
  .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
  .req_page(req_page), .req_ifetch(req_ifetch),
  .fill_valid(fill_valid), .fill_page(fill_page), .fill_class(fill_class),
  .sd_valid(sd_valid), .sd_page(sd_page), .sd_core(sd_core), .sd_kind(sd_kind),
  .sd_ack(sd_ack), .q_count(q_count)
);

// File: tb/pc_classifier_bench.sv
module pc_classifier_bench;
  localparam int CLK_PERIOD = 10;
  localparam int PW = 4;
  localparam int CW = 4;
  localparam logic [1:0] PRIV = 2'b01, SHR = 2'b10, INS = 2'b11;

  logic clk = 1'b0, rst = 1'b1;
  logic req_valid = 1'b0, req_ready, req_migrate = 1'b0, req_ifetch = 1'b0;
  logic [PW-1:0] req_page = '0;
  logic [CW-1:0] req_core = '0;
  logic fill_valid, sd_valid, sd_kind, sd_ack = 1'b0;
  logic [PW-1:0] fill_page, sd_page;
  logic [CW-1:0] fill_core, sd_core;
  logic [1:0] fill_class;

  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pc_classifier u_pc_classifier (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_page(req_page), .req_core(req_core), .req_migrate(req_migrate),
    .req_ifetch(req_ifetch), .fill_valid(fill_valid), .fill_page(fill_page),
    .fill_core(fill_core), .fill_class(fill_class), .sd_valid(sd_valid),
    .sd_page(sd_page), .sd_core(sd_core), .sd_kind(sd_kind), .sd_ack(sd_ack)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Present a request at negedge; returns whether it was accepted at the next edge.
  task automatic send(input int pg, input int cr, input bit mig, input bit ifx, output bit took);
    @(negedge clk);
    req_valid = 1'b1; req_page = PW'(pg); req_core = CW'(cr);
    req_migrate = mig; req_ifetch = ifx;
    #1 took = req_ready;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0; req_migrate = 1'b0; req_ifetch = 1'b0;
  endtask

  // Probe ready combinationally without accepting anything.
  task automatic probe(input int pg, input int cr, input bit mig, output bit rdy);
    @(negedge clk);
    req_valid = 1'b0; req_page = PW'(pg); req_core = CW'(cr); req_migrate = mig;
    req_ifetch = 1'b0;
    #1 rdy = req_ready;
    req_migrate = 1'b0;
  endtask

  task automatic expect_fill(input string tag, input int pg, input int cr, input logic [1:0] cls);
    chk(fill_valid && fill_page == PW'(pg) && fill_core == CW'(cr) && fill_class == cls, tag,
        {fill_valid, fill_page, fill_core, fill_class}, {1'b1, PW'(pg), CW'(cr), cls});
  endtask

  task automatic pulse_ack;
    @(negedge clk); sd_ack = 1'b1;
    @(negedge clk); sd_ack = 1'b0;
  endtask

  initial begin
    bit t;
    repeat (3) @(posedge clk);
    @(negedge clk) rst = 1'b0;
    #1;
    // R9 reset state
    chk(!fill_valid && !sd_valid && req_ready, "R9 reset outputs",
        {fill_valid, sd_valid, req_ready}, 3'b001);

    // R1 first touch of every page
    for (int p = 0; p < 16; p++) begin
      send(p, p % 4, 1'b0, 1'b0, t);
      expect_fill("R1 first touch private", p, p % 4, PRIV);
    end
    // R2 owner hits, no shoot-down
    for (int p = 0; p < 16; p++) begin
      send(p, p % 4, 1'b0, 1'b0, t);
      expect_fill("R2 owner hit private", p, p % 4, PRIV);
      chk(!sd_valid, "R2 no shoot-down", sd_valid, 0);
    end

    // R7 instruction fetch to unowned-core page leaves table alone
    send(5, 9, 1'b0, 1'b1, t);
    expect_fill("R7 ifetch instr", 5, 9, INS);
    send(5, 1, 1'b0, 1'b0, t);
    expect_fill("R7 table untouched by ifetch", 5, 1, PRIV);

    // R4 true sharing on page 2 (owner 2)
    send(2, 7, 1'b0, 1'b0, t);
    chk(t && !fill_valid, "R4 held no fill", fill_valid, 0);
    chk(sd_valid && sd_kind && sd_page == 4'd2 && sd_core == 4'd2, "R4 shoot-down cmd",
        {sd_valid, sd_kind, sd_page, sd_core}, {1'b1, 1'b1, 4'd2, 4'd2});
    send(2, 3, 1'b0, 1'b0, t);
    chk(t && !fill_valid, "R4 second held", fill_valid, 0);
    probe(6, 6, 1'b0, t);
    chk(!t, "R8 other page stalled", t, 0);
    send(9, 1, 1'b0, 1'b1, t);
    expect_fill("R7 ifetch during wait", 9, 1, INS);
    send(2, 5, 1'b0, 1'b0, t);
    send(2, 6, 1'b0, 1'b0, t);
    probe(2, 8, 1'b0, t);
    chk(!t, "R8 queue full stall", t, 0);
    repeat (3) @(negedge clk);
    chk(sd_valid && sd_kind && sd_page == 4'd2, "R10 command held", sd_valid, 1);
    // R5 drain
    @(negedge clk); sd_ack = 1'b1;
    @(negedge clk); sd_ack = 1'b0;
    chk(!sd_valid, "R10 release after ack", sd_valid, 0);
    probe(2, 0, 1'b0, t);
    chk(!t, "R8 stalled during drain", t, 0);
    // probe consumed the cycle in which the first parked fill appears
    expect_fill("R5 drain order 1", 2, 7, SHR);
    @(negedge clk); expect_fill("R5 drain order 2", 2, 3, SHR);
    @(negedge clk); expect_fill("R5 drain order 3", 2, 5, SHR);
    @(negedge clk); expect_fill("R5 drain order 4", 2, 6, SHR);
    @(negedge clk);
    chk(!fill_valid && req_ready, "R5 drain done", {fill_valid, req_ready}, 2'b01);

    // R6 shared is permanent
    for (int c = 0; c < 4; c++) begin
      send(2, c, c[0], 1'b0, t);
      expect_fill("R6 shared stays", 2, c, SHR);
      chk(!sd_valid, "R6 no new shoot-down", sd_valid, 0);
    end

    // R3 migration on page 4 (owner 0) to core 3
    send(4, 3, 1'b1, 1'b0, t);
    chk(!fill_valid && sd_valid && !sd_kind && sd_core == 4'd0 && sd_page == 4'd4,
        "R3 invalidate cmd", {fill_valid, sd_valid, sd_kind, sd_core},
        {1'b0, 1'b1, 1'b0, 4'd0});
    probe(4, 1, 1'b0, t);
    chk(!t, "R8 migration blocks data", t, 0);
    pulse_ack();
    @(negedge clk);
    expect_fill("R3 private to new owner", 4, 3, PRIV);
    @(negedge clk);
    send(4, 3, 1'b0, 1'b0, t);
    expect_fill("R3 new owner hit", 4, 3, PRIV);
    chk(!sd_valid, "R3 no shoot-down for new owner", sd_valid, 0);
    send(4, 0, 1'b0, 1'b0, t);
    chk(sd_valid && sd_kind && sd_core == 4'd3, "R3 owner rewritten", sd_core, 3);
    pulse_ack();
    @(negedge clk);
    expect_fill("R5 single drain", 4, 0, SHR);

    repeat (2) @(negedge clk);
    done = 1'b1;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual=hung expected=finish");
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule